// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates one of sixteen compare predicates on a pair of IEEE-754 operands, in single or double precision. Each operand pair falls into exactly one relation: unordered (at least one operand is a NaN), equal, less-than, or greater-than. A 4-bit condition code picks which of the first three relations make the predicate true, and says whether the compare is quiet or signalling. The greater-than relation is never selectable on its own. To test for it, the caller swaps the operands or inverts the result.

The unit produces only a one-bit predicate and an invalid-operation flag. It writes no register result. The caller keeps the flag and the condition bit wherever it needs them. One compare can be issued every cycle. The answer appears, with a valid strobe, one clock after the request. In a compare instruction whose function field lies in 48..63, the condition code is the function value minus 48.

Top module: `fp_cmp_pred`

## Requirements
- R1: During and after reset, `res_valid`, `res_true` and `res_invalid` are 0 until a request is accepted.
- R2: `res_valid` is 1 exactly one cycle after `req_valid` is 1. In any cycle where `res_valid` is 0, `res_true` and `res_invalid` are 0.
- R3: `cond[2:0]` is a relation mask:
  - bit 0 selects unordered.
  - bit 1 selects equal.
  - bit 2 selects less-than.
  - `res_true` is 1 exactly when the relation holding for (a, b) is in the mask.
  - Code 0 is never true, and code 7 is true for every pair except a > b.
- R4: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, the pair is unordered and is neither equal nor less.
- R5: Positive zero and negative zero compare equal.
- R6: Ordered values compare by their numeric value. This holds for negative operands, which are stored as sign and magnitude.
- R7: When `cond[3]` is 1 (signalling form), an unordered pair sets `res_invalid`.
- R8: A signalling NaN operand sets `res_invalid` even when `cond[3]` is 0. A signalling NaN has the fraction MSB equal to 0 and a nonzero fraction.
- R9: In the quiet form, a pair containing only quiet NaNs (fraction MSB 1) does not set `res_invalid`.
- R10: With `dbl`=0, the operands are taken from bits 31:0 (1 sign, 8 exponent, 23 fraction bits), and bits 63:32 have no effect. With `dbl`=1, all 64 bits are used (1 sign, 11 exponent, 52 fraction bits).
- R11: Infinities are ordered values. +inf equals +inf, and -inf is less than every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| cond | input | 4 | [2:0] relation mask, [3] signalling form |
| op_a | input | 64 | First operand bit pattern |
| op_b | input | 64 | Second operand bit pattern |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_true | output | 1 | Predicate outcome |
| res_invalid | output | 1 | Invalid-operation indication |

## Verification
The only state is the one-stage result register, so a wrong classification or mask test shows up on `res_true` or `res_invalid` in the cycle right after the request. It never lingers beyond that cycle. The bench model computes the expected pair every cycle from an ordered integer key built from sign and magnitude, and compares all three outputs at each clock.
- All sixteen codes are swept against less, greater, equal, unordered and signed-zero pairs.
- Negative and infinite operands, signalling NaNs in the quiet form, and junk in the upper half of single operands are exercised.
- A latency slip, or a flag left set during idle cycles, surfaces within one cycle.

// File: rtl/fp_cmp_pred.sv
module fp_cmp_pred #(
  parameter int DW   = 64,
  parameter int DEXP = 11,
  parameter int SW   = 32,
  parameter int SEXP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          dbl,
  input  logic [3:0]    cond,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  output logic          res_true,
  output logic          res_invalid
);
  localparam int DMAN = DW - 1 - DEXP;
  localparam int SMAN = SW - 1 - SEXP;

  logic          a_sign, b_sign, a_eones, b_eones, a_fnz, b_fnz, a_qbit, b_qbit;
  logic [DW-2:0] a_mag, b_mag;

  assign a_sign  = dbl ? op_a[DW-1] : op_a[SW-1];
  assign b_sign  = dbl ? op_b[DW-1] : op_b[SW-1];
  assign a_eones = dbl ? &op_a[DW-2 -: DEXP] : &op_a[SW-2 -: SEXP];
  assign b_eones = dbl ? &op_b[DW-2 -: DEXP] : &op_b[SW-2 -: SEXP];
  assign a_fnz   = dbl ? |op_a[DMAN-1:0] : |op_a[SMAN-1:0];
  assign b_fnz   = dbl ? |op_b[DMAN-1:0] : |op_b[SMAN-1:0];
  assign a_qbit  = dbl ? op_a[DMAN-1] : op_a[SMAN-1];
  assign b_qbit  = dbl ? op_b[DMAN-1] : op_b[SMAN-1];
  assign a_mag   = dbl ? op_a[DW-2:0] : {{(DW-SW){1'b0}}, op_a[SW-2:0]};
  assign b_mag   = dbl ? op_b[DW-2:0] : {{(DW-SW){1'b0}}, op_b[SW-2:0]};

  logic a_nan, b_nan, a_snan, b_snan, unord, zeros, eq, lt, hit, inv;

  assign a_nan  = a_eones & a_fnz;
  assign b_nan  = b_eones & b_fnz;
  assign a_snan = a_nan & ~a_qbit;
  assign b_snan = b_nan & ~b_qbit;
  assign unord  = a_nan | b_nan;
  assign zeros  = (a_mag == '0) && (b_mag == '0);
  assign eq     = ~unord & (zeros | ((a_sign == b_sign) && (a_mag == b_mag)));
  assign lt     = ~unord & ~eq &
                  ((a_sign & ~b_sign) |
                   (~a_sign & ~b_sign & (a_mag < b_mag)) |
                   (a_sign & b_sign & (a_mag > b_mag)));
  assign hit    = (cond[0] & unord) | (cond[1] & eq) | (cond[2] & lt);
  assign inv    = (cond[3] & unord) | a_snan | b_snan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_true    <= 1'b0;
      res_invalid <= 1'b0;
    end else begin
      res_valid   <= req_valid;
      res_true    <= req_valid & hit;
      res_invalid <= req_valid & inv;
    end
  end

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_true && !res_invalid));
  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond[2:0] == 3'd0) |=> !res_true);
  assert_unord_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && unord && cond[2:0] == 3'd6) |=> !res_true);
  assert_sig_unord_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond[3] && unord) |=> res_invalid);
  assert_snan_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (a_snan || b_snan)) |=> res_invalid);
endmodule

// File: tb/test_fp_cmp_pred.sv
module test_fp_cmp_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        dbl = 1'b0;
  logic [3:0]  cond = 4'd0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid, res_true, res_invalid;

  int errors = 0;
  int checks = 0;
  logic       e_v = 1'b0, e_t = 1'b0, e_i = 1'b0;
  string      e_tag = "R1";

  always #5 clk = ~clk;

  fp_cmp_pred i_fp_cmp_pred (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dbl(dbl), .cond(cond),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_true(res_true),
    .res_invalid(res_invalid)
  );

  // Model: 0 unordered, 1 equal, 2 less, 3 greater; bit 2 of return = invalid
  function automatic logic [2:0] model(input logic d, input logic [3:0] c,
                                       input logic [63:0] a, input logic [63:0] b);
    longint emax, ea, eb, ma, mb, ka, kb, fbit;
    logic sa, sb, na, nb, qa, qb;
    int rel;
    logic t, inv;
    if (d) begin
      emax = 2047; fbit = 51;
      sa = a[63]; sb = b[63];
      ea = longint'(a[62:52]); eb = longint'(b[62:52]);
      ma = longint'(a[51:0]);  mb = longint'(b[51:0]);
      ka = longint'(a[62:0]);  kb = longint'(b[62:0]);
    end else begin
      emax = 255; fbit = 22;
      sa = a[31]; sb = b[31];
      ea = longint'(a[30:23]); eb = longint'(b[30:23]);
      ma = longint'(a[22:0]);  mb = longint'(b[22:0]);
      ka = longint'(a[30:0]);  kb = longint'(b[30:0]);
    end
    na = (ea == emax) && (ma != 0);
    nb = (eb == emax) && (mb != 0);
    qa = ma[fbit];
    qb = mb[fbit];
    if (sa) ka = -ka;
    if (sb) kb = -kb;
    if (na || nb) rel = 0;
    else if (ka == kb) rel = 1;
    else if (ka < kb) rel = 2;
    else rel = 3;
    t = (rel < 3) ? c[rel] : 1'b0;
    inv = (c[3] && rel == 0) || (na && !qa) || (nb && !qb);
    return {inv, t, 1'b1};
  endfunction

  task automatic cmp_now;
    checks++;
    if (res_valid !== e_v || res_true !== e_t || res_invalid !== e_i) begin
      errors++;
      $display("FAIL %s: got v/t/i=%b%b%b expected %b%b%b", e_tag,
               res_valid, res_true, res_invalid, e_v, e_t, e_i);
    end
  endtask

  task automatic step(input logic v, input logic d, input logic [3:0] c,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [2:0] m;
    @(negedge clk);
    cmp_now();
    req_valid = v; dbl = d; cond = c; op_a = a; op_b = b;
    m = model(d, c, a, b);
    e_v = v; e_t = v & m[1]; e_i = v & m[2]; e_tag = tag;
  endtask

  localparam logic [63:0] S1   = 64'h3F800000;
  localparam logic [63:0] S2   = 64'h40000000;
  localparam logic [63:0] SM2  = 64'hC0000000;
  localparam logic [63:0] SM3  = 64'hC0400000;
  localparam logic [63:0] SQN  = 64'h7FC00000;
  localparam logic [63:0] SSN  = 64'h7F800001;
  localparam logic [63:0] SINF = 64'h7F800000;
  localparam logic [63:0] SNIN = 64'hFF800000;
  localparam logic [63:0] SNZ  = 64'h80000000;
  localparam logic [63:0] D1   = 64'h3FF0000000000000;
  localparam logic [63:0] D2   = 64'h4000000000000000;
  localparam logic [63:0] DM1  = 64'hBFF0000000000000;
  localparam logic [63:0] DQN  = 64'h7FF8000000000000;
  localparam logic [63:0] DSN  = 64'h7FF0000000000001;
  localparam logic [63:0] DNZ  = 64'h8000000000000000;

  initial begin
    repeat (3) @(negedge clk);
    e_tag = "R1"; cmp_now();
    rst_n = 1'b1;
    @(negedge clk); e_tag = "R1"; cmp_now();
    for (int c = 0; c < 16; c++) begin
      step(1, 0, 4'(c), S1, S2, "R3");
      step(1, 0, 4'(c), S2, S1, "R3");
      step(1, 0, 4'(c), S1, S1, "R3");
      step(1, 0, 4'(c), SQN, S1, "R4");
      step(1, 0, 4'(c), SNZ, 64'h0, "R5");
      step(1, 1, 4'(c), D1, D2, "R10");
      step(1, 1, 4'(c), D2, DQN, "R7");
      step(1, 1, 4'(c), DNZ, 64'h0, "R5");
    end
    step(1, 0, 4'd4, SM3, SM2, "R6");
    step(1, 0, 4'd4, SM2, SM3, "R6");
    step(1, 1, 4'd4, DM1, D1, "R6");
    step(1, 1, 4'd6, DM1, DM1, "R6");
    step(0, 0, 4'd7, S1, S1, "R2");
    step(0, 0, 4'd9, SQN, SQN, "R2");
    step(1, 0, 4'd1, SSN, S1, "R8");
    step(1, 1, 4'd2, D1, DSN, "R8");
    step(1, 0, 4'd1, SQN, SQN, "R9");
    step(1, 1, 4'd7, DQN, D1, "R9");
    step(1, 0, 4'd2, {32'hFFFFFFFF, S1[31:0]}, {32'h7FF80000, S1[31:0]}, "R10");
    step(1, 0, 4'd4, {32'h12345678, S1[31:0]}, S2, "R10");
    step(1, 0, 4'd2, SINF, SINF, "R11");
    step(1, 0, 4'd4, SNIN, SM3, "R11");
    step(1, 0, 4'd4, S2, SINF, "R11");
    step(1, 1, 4'd4, 64'hFFF0000000000000, DM1, "R11");
    step(0, 0, 4'd0, '0, '0, "R2");
    step(0, 0, 4'd0, '0, '0, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule